// File: doc/BRIEF.md
# Segmented JTAG Shift Master

This block is a host-side JTAG master. It moves one segment of 1 to 32 bits through TDI and TDO for each command. The command also sets the bit order, whether the segment closes the shift state, and where the TAP controller ends up. Three more commands move the TAP controller without shifting data: one resets it, one walks it to Shift-IR and one walks it to Shift-DR. A register longer than 32 bits is shifted as several segments in a row. Only the last segment sets the end flag, so a 38-bit chain is sent as segments of 32, 5 and 1 bits.

TCK comes from the system clock. A divider sets each TCK half-period as a whole number of system clocks, and TCK rests low between commands. TDI and TMS change on the falling TCK edge, which comes before the rising edge where the target samples them. TDO is captured on the falling edge. The captured bits are put back together in the command's bit order. The result is returned with a one-clock completion pulse.

Top module: `jtag_seg_master`

## Requirements
- R1: A shift command (op_i = 0) sends n bits, where n = nbits_i. A value of 0 or above 32 is taken as 32. With msb_first_i = 0, step k sends data_i[k]. With msb_first_i = 1, step k sends data_i[n-1-k].
- R2: TCK is low whenever no command is running. Each TCK cycle is low for H system clocks and then high for H system clocks. H is half_div_i as sampled at start, with 0 taken as 1. The first low phase begins in the clock after start is accepted.
- R3: TMS and TDI change only when a command is accepted or when TCK falls. TDO is sampled in the system clock where TCK falls.
- R4: With end_i = 1, TMS is high during the last data bit. With end_i = 0, TMS is low for every bit and no TCK cycles follow the data.
- R5: After a segment with end_i = 1, two more TCK cycles follow with TDI low. TMS is 1 then 0 when idle_i = 1, which ends in Run-Test/Idle. TMS is 1 then 1 when idle_i = 0, which ends in Select-DR-Scan.
- R6: The bit captured in the step that sent data index i lands in result bit i. Result bits at and above n are 0. Every other command returns 0. result_o changes only when a command completes.
- R7: The reset command (op_i = 1) drives five TCK cycles with TMS high, then one with TMS low. TDI stays low.
- R8: Go-to-Shift-IR (op_i = 2) drives TMS 1,1,0,0. Go-to-Shift-DR (op_i = 3) drives TMS 1,0,0. TDI stays low in both.
- R9: After reset, busy_o, done_o, tck_o, tms_o, tdi_o and result_o are all 0. busy_o rises in the clock after start is accepted and falls at the last falling TCK edge. done_o pulses for exactly that one clock. A start while busy_o is high is ignored.
- R10: Segments of 32, 5 and 1 bits, with the end flag only on the last, leave the TAP controller in Shift-DR between segments. After the last segment it is in Run-Test/Idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a command; accepted only while idle |
| op_i | input | 2 | 0 shift, 1 TAP reset, 2 to Shift-IR, 3 to Shift-DR |
| nbits_i | input | 6 | Segment length (0 or >32 means 32) |
| data_i | input | 32 | Word to send |
| msb_first_i | input | 1 | 1 selects MSB-first order |
| end_i | input | 1 | Raise TMS on the last bit |
| idle_i | input | 1 | After end, go to Run-Test/Idle rather than Select-DR-Scan |
| half_div_i | input | 8 | TCK half-period in system clocks |
| tdo_i | input | 1 | Serial data from the target |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-clock completion pulse |
| result_o | output | 32 | Captured TDO word |
| tck_o | output | 1 | Test clock |
| tms_o | output | 1 | Test mode select |
| tdi_o | output | 1 | Serial data to the target |

## Verification
Two things can happen in the same system clock. The falling TCK edge that ends the last step must complete the command, clearing busy, pulsing done and loading the result. A new start can also arrive in that clock, or during any other busy cycle. The bench pulses a conflicting start in the middle of a running segment, and also runs commands one after another so that the next start lands right after done. A behavioural reference built from command queues checks that the stray start leaves no trace on TCK, TMS, busy or the result. A TAP state tracker driven from tck_o and tms_o checks the state after each command.

// File: rtl/jsm_pkg.sv
package jsm_pkg;
  typedef enum logic [1:0] {
    OP_SHIFT = 2'd0,
    OP_RESET = 2'd1,
    OP_GO_IR = 2'd2,
    OP_GO_DR = 2'd3
  } jsm_op_e;

  localparam int RESET_HI_CYC = 5;
  localparam int GO_IR_CYC    = 4;
  localparam int GO_DR_CYC    = 3;
  localparam int TAIL_CYC     = 2;
endpackage

// File: rtl/jsm_tck_gen.sv
module jsm_tck_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             run_i,
  output logic             tck_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] half_m1_q, ph_q;
  logic             tck_q;
  logic             last_ph;

  assign last_ph = (ph_q == half_m1_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_m1_q <= '0;
      ph_q      <= '0;
      tck_q     <= 1'b0;
    end else if (load_i) begin
      half_m1_q <= (div_i == '0) ? '0 : div_i - DIV_W'(1);
      ph_q      <= '0;
      tck_q     <= 1'b0;
    end else if (run_i) begin
      if (last_ph) begin
        ph_q  <= '0;
        tck_q <= ~tck_q;
      end else begin
        ph_q <= ph_q + DIV_W'(1);
      end
    end
  end

  assign tck_o  = tck_q;
  assign fall_o = run_i & last_ph & tck_q;

  // R2
  tck_idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> !tck_q);

  // R2
  tck_phase_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_q <= half_m1_q);
endmodule

// File: rtl/jsm_seq.sv
module jsm_seq
  import jsm_pkg::*;
#(
  parameter int MAX_BITS = 32,
  parameter int CNT_W    = $clog2(MAX_BITS + 1),
  parameter int STP_W    = $clog2(MAX_BITS + TAIL_CYC + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  jsm_op_e          op_i,
  input  logic [CNT_W-1:0] nbits_i,
  input  logic             end_i,
  input  logic             idle_i,
  input  logic             fall_i,
  output logic             load_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             fin_o,
  output logic             shift_act_o,
  output logic [STP_W-1:0] step_o,
  output logic [STP_W-1:0] n_o,
  output logic             tms_o
);
  localparam logic [STP_W-1:0] MAXB = STP_W'(MAX_BITS);

  jsm_op_e          op_q;
  logic [STP_W-1:0] n_q, step_q, total, n_in, n_eff;
  logic             end_q, idle_q, busy_q, done_q, last_step, tms_raw;

  assign n_in   = STP_W'(nbits_i);
  assign n_eff  = (n_in == '0 || n_in > MAXB) ? MAXB : n_in;
  assign load_o = start_i & ~busy_q;

  always_comb begin
    unique case (op_q)
      OP_SHIFT: total = n_q + (end_q ? STP_W'(TAIL_CYC) : '0);
      OP_RESET: total = STP_W'(RESET_HI_CYC + 1);
      OP_GO_IR: total = STP_W'(GO_IR_CYC);
      default:  total = STP_W'(GO_DR_CYC);
    endcase
  end

  assign last_step = (step_q == total - STP_W'(1));
  assign fin_o     = busy_q & fall_i & last_step;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q   <= OP_SHIFT;
      n_q    <= '0;
      end_q  <= 1'b0;
      idle_q <= 1'b0;
      step_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (load_o) begin
      op_q   <= op_i;
      n_q    <= n_eff;
      end_q  <= end_i;
      idle_q <= idle_i;
      step_q <= '0;
      busy_q <= 1'b1;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (busy_q && fall_i) begin
        if (last_step) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          step_q <= '0;
        end else begin
          step_q <= step_q + STP_W'(1);
        end
      end
    end
  end

  always_comb begin
    unique case (op_q)
      OP_SHIFT: begin
        if (step_q < n_q)       tms_raw = end_q && (step_q == n_q - STP_W'(1));
        else if (step_q == n_q) tms_raw = 1'b1;
        else                    tms_raw = ~idle_q;
      end
      OP_RESET: tms_raw = (step_q < STP_W'(RESET_HI_CYC));
      OP_GO_IR: tms_raw = (step_q < STP_W'(2));
      default:  tms_raw = (step_q == '0);
    endcase
  end

  assign tms_o       = busy_q & tms_raw;
  assign shift_act_o = busy_q && (op_q == OP_SHIFT) && (step_q < n_q);
  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign step_o      = step_q;
  assign n_o         = n_q;

  // R9
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  // R9
  done_not_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !busy_q);

  // R3
  tms_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !fall_i) |=> $stable(tms_o));

  // R4
  no_end_tms_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && op_q == OP_SHIFT && !end_q) |-> !tms_o);

  // R9
  start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !fall_i) |=> busy_q && $stable(op_q));
endmodule

// File: rtl/jsm_shifter.sv
module jsm_shifter #(
  parameter int MAX_BITS = 32,
  parameter int STP_W    = 6,
  parameter int IDX_W    = $clog2(MAX_BITS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [MAX_BITS-1:0] data_i,
  input  logic                msb_i,
  input  logic                shift_act_i,
  input  logic                fall_i,
  input  logic                fin_i,
  input  logic [STP_W-1:0]    step_i,
  input  logic [STP_W-1:0]    n_i,
  input  logic                tdo_i,
  output logic                tdi_o,
  output logic [MAX_BITS-1:0] result_o
);
  logic [MAX_BITS-1:0] data_q, acc_q, acc_nxt, res_q;
  logic                msb_q;
  logic [IDX_W-1:0]    idx;

  assign idx = IDX_W'(msb_q ? (n_i - STP_W'(1) - step_i) : step_i);

  always_comb begin
    acc_nxt = acc_q;
    if (fall_i && shift_act_i) acc_nxt[idx] = tdo_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      msb_q  <= 1'b0;
      acc_q  <= '0;
      res_q  <= '0;
    end else if (load_i) begin
      data_q <= data_i;
      msb_q  <= msb_i;
      acc_q  <= '0;
    end else begin
      acc_q <= acc_nxt;
      if (fin_i) res_q <= acc_nxt;
    end
  end

  assign tdi_o    = shift_act_i & data_q[idx];
  assign result_o = res_q;

  // R3
  tdi_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_act_i && !fall_i && !load_i) |=> $stable(tdi_o));

  // R6
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fin_i |=> $stable(res_q));
endmodule

// File: rtl/jtag_seg_master.sv
module jtag_seg_master
  import jsm_pkg::*;
#(
  parameter int  MAX_BITS = 32,
  parameter int  DIV_W    = 8,
  localparam int CNT_W    = $clog2(MAX_BITS + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [1:0]          op_i,
  input  logic [CNT_W-1:0]    nbits_i,
  input  logic [MAX_BITS-1:0] data_i,
  input  logic                msb_first_i,
  input  logic                end_i,
  input  logic                idle_i,
  input  logic [DIV_W-1:0]    half_div_i,
  input  logic                tdo_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [MAX_BITS-1:0] result_o,
  output logic                tck_o,
  output logic                tms_o,
  output logic                tdi_o
);
  localparam int STP_W = $clog2(MAX_BITS + TAIL_CYC + 1);

  logic             load, fall, fin, shift_act;
  logic [STP_W-1:0] step, n_cur;

  jsm_tck_gen #(.DIV_W(DIV_W)) u_tck (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .div_i  (half_div_i),
    .run_i  (busy_o),
    .tck_o  (tck_o),
    .fall_o (fall)
  );

  jsm_seq #(.MAX_BITS(MAX_BITS), .CNT_W(CNT_W), .STP_W(STP_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .op_i        (jsm_op_e'(op_i)),
    .nbits_i     (nbits_i),
    .end_i       (end_i),
    .idle_i      (idle_i),
    .fall_i      (fall),
    .load_o      (load),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .fin_o       (fin),
    .shift_act_o (shift_act),
    .step_o      (step),
    .n_o         (n_cur),
    .tms_o       (tms_o)
  );

  jsm_shifter #(.MAX_BITS(MAX_BITS), .STP_W(STP_W)) u_shf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .data_i      (data_i),
    .msb_i       (msb_first_i),
    .shift_act_i (shift_act),
    .fall_i      (fall),
    .fin_i       (fin),
    .step_i      (step),
    .n_i         (n_cur),
    .tdo_i       (tdo_i),
    .tdi_o       (tdi_o),
    .result_o    (result_o)
  );

  // R9
  done_after_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o && !tck_o);

  // R5
  tail_tdi_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !shift_act) |-> !tdi_o);
endmodule

// File: tb/jtag_seg_master_test.sv
`timescale 1ns/1ps
module jtag_seg_master_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  op_i = '0;
  logic [5:0]  nbits_i = '0;
  logic [31:0] data_i = '0;
  logic        msb_first_i = 1'b0, end_i = 1'b0, idle_i = 1'b0;
  logic [7:0]  half_div_i = 8'd1;
  logic        tdo_i = 1'b0;
  logic        busy_o, done_o, tck_o, tms_o, tdi_o;
  logic [31:0] result_o;

  int vectors = 0;
  int fails = 0;
  bit finished = 0;
  bit loop_en = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2.5 clk_i = ~clk_i;

  jtag_seg_master uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .op_i(op_i),
    .nbits_i(nbits_i), .data_i(data_i), .msb_first_i(msb_first_i),
    .end_i(end_i), .idle_i(idle_i), .half_div_i(half_div_i), .tdo_i(tdo_i),
    .busy_o(busy_o), .done_o(done_o), .result_o(result_o),
    .tck_o(tck_o), .tms_o(tms_o), .tdi_o(tdi_o)
  );

  // target TDO source: loopback of TDI or pseudo-random
  always @(negedge clk_i) begin
    tdo_i <= loop_en ? tdi_o : lfsr[0];
    lfsr  <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  end

  // behavioural reference
  bit          m_busy, m_done, m_tck;
  int          m_ph, m_h;
  logic [31:0] m_acc, m_res;
  bit          m_tms_q[$];
  bit          m_tdi_q[$];
  int          m_cap_q[$];

  task automatic push(bit t, bit d, int c);
    m_tms_q.push_back(t); m_tdi_q.push_back(d); m_cap_q.push_back(c);
  endtask

  task automatic build();
    int n;
    case (op_i)
      2'd0: begin
        n = (nbits_i == 0 || nbits_i > 32) ? 32 : int'(nbits_i);
        for (int i = 0; i < n; i++) begin
          int ix = msb_first_i ? n - 1 - i : i;
          push(end_i && (i == n - 1), data_i[ix], ix);
        end
        if (end_i) begin
          push(1'b1, 1'b0, -1);
          push(!idle_i, 1'b0, -1);
        end
      end
      2'd1: begin
        for (int i = 0; i < 5; i++) push(1'b1, 1'b0, -1);
        push(1'b0, 1'b0, -1);
      end
      2'd2: begin push(1,0,-1); push(1,0,-1); push(0,0,-1); push(0,0,-1); end
      default: begin push(1,0,-1); push(0,0,-1); push(0,0,-1); end
    endcase
  endtask

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_busy = 0; m_done = 0; m_tck = 0; m_ph = 0; m_h = 1;
      m_acc = '0; m_res = '0;
      m_tms_q.delete(); m_tdi_q.delete(); m_cap_q.delete();
    end else begin
      m_done = 0;
      if (!m_busy) begin
        if (start_i) begin
          build();
          m_busy = 1; m_tck = 0; m_ph = 0; m_acc = '0;
          m_h = (half_div_i == 0) ? 1 : int'(half_div_i);
        end
      end else if (m_ph == m_h - 1) begin
        m_ph = 0;
        if (!m_tck) m_tck = 1;
        else begin
          m_tck = 0;
          if (m_cap_q[0] >= 0) m_acc[m_cap_q[0]] = tdo_i;
          void'(m_tms_q.pop_front()); void'(m_tdi_q.pop_front()); void'(m_cap_q.pop_front());
          if (m_tms_q.size() == 0) begin
            m_busy = 0; m_done = 1; m_res = m_acc;
          end
        end
      end else m_ph++;
    end
  end

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_ni && !finished) begin
      bit e_tms, e_tdi;
      e_tms = (m_busy && m_tms_q.size() > 0) ? m_tms_q[0] : 1'b0;
      e_tdi = (m_busy && m_tdi_q.size() > 0) ? m_tdi_q[0] : 1'b0;
      vectors++;
      if (busy_o !== m_busy)  begin fails++; $display("FAIL R9 busy act=%0b exp=%0b t=%0t", busy_o, m_busy, $time); end
      if (done_o !== m_done)  begin fails++; $display("FAIL R9 done act=%0b exp=%0b t=%0t", done_o, m_done, $time); end
      if (tck_o !== m_tck)    begin fails++; $display("FAIL R2 tck act=%0b exp=%0b t=%0t", tck_o, m_tck, $time); end
      if (tms_o !== e_tms)    begin fails++; $display("FAIL R4 tms act=%0b exp=%0b t=%0t", tms_o, e_tms, $time); end
      if (tdi_o !== e_tdi)    begin fails++; $display("FAIL R1 tdi act=%0b exp=%0b t=%0t", tdi_o, e_tdi, $time); end
      if (result_o !== m_res) begin fails++; $display("FAIL R6 result act=%0h exp=%0h t=%0t", result_o, m_res, $time); end
    end
  end

  // TAP state tracker
  typedef enum int {TLR, RTI, SDS, CDR, SDR, E1D, PDR, E2D, UDR,
                    SIS, CIR, SIR, E1I, PIR, E2I, UIR} tap_e;
  tap_e tap = TLR;

  function automatic tap_e tap_nxt(tap_e s, bit m);
    case (s)
      TLR: return m ? TLR : RTI;
      RTI: return m ? SDS : RTI;
      SDS: return m ? SIS : CDR;
      CDR: return m ? E1D : SDR;
      SDR: return m ? E1D : SDR;
      E1D: return m ? UDR : PDR;
      PDR: return m ? E2D : PDR;
      E2D: return m ? UDR : SDR;
      UDR: return m ? SDS : RTI;
      SIS: return m ? TLR : CIR;
      CIR: return m ? E1I : SIR;
      SIR: return m ? E1I : SIR;
      E1I: return m ? UIR : PIR;
      PIR: return m ? E2I : PIR;
      E2I: return m ? UIR : SIR;
      default: return m ? SDS : RTI;
    endcase
  endfunction

  always @(posedge tck_o) tap <= tap_nxt(tap, tms_o);

  task automatic run(int op, int n, logic [31:0] d, bit msb, bit en, bit idl, int div);
    @(negedge clk_i);
    op_i = 2'(op); nbits_i = 6'(n); data_i = d; msb_first_i = msb;
    end_i = en; idle_i = idl; half_div_i = 8'(div); start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    while (!done_o) @(negedge clk_i);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    fails++;
    $display("FAIL R9 watchdog act=0 exp=1");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R9 reset state
    chk(!busy_o && !done_o && !tck_o && !tms_o && !tdi_o, "R9 reset outputs",
        {busy_o, done_o, tck_o, tms_o, tdi_o}, 0);
    chk(result_o == 0, "R9 reset result", result_o, 0);
    rst_ni = 1'b1;

    run(1, 0, 0, 0, 0, 0, 1);
    chk(tap == RTI, "R7 reset to idle", tap, RTI);
    run(3, 0, 0, 0, 0, 0, 2);
    chk(tap == SDR, "R8 go shift-dr", tap, SDR);
    chk(result_o == 0, "R6 non-shift result", result_o, 0);

    loop_en = 1;
    run(0, 8, 32'hA5C3_5A96, 0, 1, 1, 3);
    chk(result_o == 32'h96, "R6 lsb loopback", result_o, 32'h96);
    chk(tap == RTI, "R5 end to idle", tap, RTI);

    run(2, 0, 0, 0, 0, 0, 1);
    chk(tap == SIR, "R8 go shift-ir", tap, SIR);
    run(0, 4, 32'hFFFF_FFFB, 1, 1, 0, 1);
    chk(result_o == 32'hB, "R1 msb loopback 4b", result_o, 32'hB);
    chk(tap == SDS, "R5 end to select-dr", tap, SDS);

    run(1, 0, 0, 0, 0, 0, 1);
    run(3, 0, 0, 0, 0, 0, 1);
    loop_en = 0;
    run(0, 32, 32'h1234_5678, 0, 0, 0, 1);
    chk(tap == SDR, "R10 chain seg32", tap, SDR);
    chk(!tck_o && !tms_o, "R4 no-end idle pins", {tck_o, tms_o}, 0);
    run(0, 5, 32'h13, 0, 0, 1, 2);
    chk(tap == SDR, "R10 chain seg5", tap, SDR);
    run(0, 1, 32'h1, 0, 1, 1, 1);
    chk(tap == RTI, "R10 chain end", tap, RTI);

    loop_en = 1;
    run(3, 0, 0, 0, 0, 0, 1);
    run(0, 0, 32'hDEAD_BEEF, 1, 1, 1, 0);
    chk(result_o == 32'hDEAD_BEEF, "R1 zero count as 32", result_o, 32'hDEAD_BEEF);
    run(3, 0, 0, 0, 0, 0, 1);
    run(0, 40, 32'h0F1E_2D3C, 0, 1, 1, 2);
    chk(result_o == 32'h0F1E_2D3C, "R1 oversize count", result_o, 32'h0F1E_2D3C);

    // stray start while busy
    run(3, 0, 0, 0, 0, 0, 1);
    @(negedge clk_i);
    op_i = 2'd0; nbits_i = 6'd3; data_i = 32'h5; msb_first_i = 0;
    end_i = 1; idle_i = 1; half_div_i = 8'd2; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (5) @(negedge clk_i);
    op_i = 2'd1; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    while (!done_o) @(negedge clk_i);
    chk(result_o == 32'h5, "R9 stray start result", result_o, 32'h5);
    repeat (12) @(negedge clk_i);
    chk(!busy_o && tap == RTI, "R9 stray start ignored", {busy_o, 4'(tap)}, RTI);

    // result holds during the next command
    @(negedge clk_i);
    op_i = 2'd3; half_div_i = 8'd3; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (4) @(negedge clk_i);
    chk(busy_o && result_o == 32'h5, "R6 result held", result_o, 32'h5);
    while (!done_o) @(negedge clk_i);
    chk(result_o == 0, "R6 cleared by non-shift", result_o, 0);
    chk(tap == SDR, "R8 final shift-dr", tap, SDR);
    repeat (4) @(negedge clk_i);
    summary();
  end
endmodule